// File: doc/BRIEF.md
# Bus Master START Sequencer with Collision Abort

This block produces the START condition on a two-wire bus (SDA falling while SCL is high, followed by SCL falling) for a bus master. It also watches both lines for signs that another agent is already using the bus. Both outputs are open-drain style: each is a drive-low enable, and a released line is pulled high by the bus. The two line inputs pass through a two-stage synchroniser before the block bases any decision on them.

Software writes a one-cycle request pulse. The block then checks that both lines are released. It waits one baud period with SDA released and drives SDA low. It waits a second baud period and drives SCL low. The baud period is set by a 7-bit reload value that a down-counter loads. If SCL is seen low before SDA has been driven, or if either line is low when the request is first checked, the block aborts and returns to idle. It sets a sticky collision flag and withdraws its own enable. If SDA goes low early because another master started first, that is not a collision: the block drives SDA at once and continues. After a successful START both lines stay driven low until a release input is pulsed.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset, both drive-low outputs are 0, and `start_en`, `start_done`, `start_seen`, `irq_flag` and `bus_coll` are all 0.
- R2: A `start_set` pulse seen in idle sets `start_en` at that clock edge. A `start_set` while a START is running or held has no effect on any output.
- R3: On the edge after acceptance, if synchronised SDA or SCL is low, the START aborts. `bus_coll` is set, `start_en` is cleared, neither line is driven, and the block returns to idle.
- R4: The effective period is Le = `reload`, except that a reload of 0 gives Le = 1. With the bus free, `sda_drive_low` rises Le+1 edges after the accepting edge.
- R5: If synchronised SCL is low while SDA is still high during the first period, the START aborts as in R3. SCL pulled low on the bus at cycle j after acceptance is acted on at cycle j+3.
- R6: If synchronised SDA goes low during the first period, `sda_drive_low` rises on that edge with no collision. The second period then begins.
- R7: `scl_drive_low` rises Le edges after `sda_drive_low`. In that same cycle `start_done` is high for exactly one cycle and `start_en` clears. `scl_drive_low` is never 1 while `sda_drive_low` is 0.
- R8: SCL low on the bus during the second period does not raise `bus_coll`.
- R9: `start_seen` and `irq_flag` set on the edge where synchronised SDA is low and synchronised SCL is high. With its own drive, that is 3 edges after `sda_drive_low` rises.
- R10: After a successful START, both drive-low outputs stay 1 until `release_bus`, which clears both on the next edge.
- R11: `bus_coll`, `irq_flag` and `start_seen` stay set until `clr_flags` is pulsed while the setting condition is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_set | input | 1 | One-cycle request to begin a START |
| reload | input | 7 | Baud period reload value (0 behaves as 1) |
| release_bus | input | 1 | Releases both lines after a completed START |
| clr_flags | input | 1 | Clears the collision, interrupt and start-seen flags |
| sda_in | input | 1 | Raw SDA line level (1 = high) |
| scl_in | input | 1 | Raw SCL line level (1 = high) |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| start_en | output | 1 | START in progress; clears on completion or collision |
| start_done | output | 1 | One-cycle pulse when SCL is driven low at the end of a START |
| start_seen | output | 1 | START observed on the bus |
| irq_flag | output | 1 | Interrupt flag, set when a START is observed |
| bus_coll | output | 1 | Sticky bus-collision flag |

## Verification
Every result is due at a fixed edge counted from the edge that accepts the request. `start_en` is due at that edge and the pre-start abort one edge later. The SDA drive is due at Le+1 and the SCL drive with `start_done` at 2·Le+1. The start-seen flags are due three edges after SDA first goes low on the bus. A disturbance applied at cycle j is acted on at j+3 because of the two synchroniser stages and the deciding register. The bench drives stimulus on falling edges and records, for every falling edge after acceptance, the first index at which each output rises. It then compares that index with the value it computes from Le and j. It sweeps several reload values and every disturbance point across both periods.

// File: rtl/i2c_start_pkg.sv
// Package: shared state encoding for the START sequencer.
// Assumes: a single clock domain; imported by i2c_start_gen only.
package i2c_start_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_COUNT1,
        ST_COUNT2,
        ST_HOLD
    } start_state_e;
endpackage

// File: rtl/line_sync.sv
// Module: multi-stage synchroniser for a group of bus line inputs.
// Assumes: lines idle high, so every stage resets to all ones.
module line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] stg [STAGES];

    // Shift raw line levels through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= raw;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign synced = stg[STAGES-1];
endmodule

// File: rtl/baud_down_counter.sv
// Module: loadable down-counter that marks the last cycle of a baud period.
// Assumes: load_val is nonzero; the controller never decrements through zero.
module baud_down_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    // Load a new period or count the current one down
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end

    assign last = (cnt == W'(1));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt != '0));
endmodule

// File: rtl/start_flags.sv
// Module: sticky status flags (start seen, interrupt, collision) with software clear.
// Assumes: sda_s and scl_s are already synchronised; set takes priority over clear.
module start_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_s,
    input  logic scl_s,
    input  logic coll_evt,
    input  logic clr,
    output logic start_seen,
    output logic irq_flag,
    output logic bus_coll
);
    logic seen_cond;
    assign seen_cond = !sda_s && scl_s;

    // Track the start-seen status and raise the interrupt on its first detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_seen <= 1'b0;
            irq_flag   <= 1'b0;
        end else begin
            if (seen_cond)  start_seen <= 1'b1;
            else if (clr)   start_seen <= 1'b0;
            if (seen_cond && !start_seen) irq_flag <= 1'b1;
            else if (clr)                 irq_flag <= 1'b0;
        end
    end

    // Hold the collision flag until software clears it
    always_ff @(posedge clk) begin
        if (!rst_n)        bus_coll <= 1'b0;
        else if (coll_evt) bus_coll <= 1'b1;
        else if (clr)      bus_coll <= 1'b0;
    end

    // R11
    coll_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_coll && !clr) |=> bus_coll);
endmodule

// File: rtl/i2c_start_gen.sv
// Module: START sequencer for a bus master with collision abort (top).
// Assumes: open-drain bus (outputs are drive-low enables); raw line inputs are
// asynchronous and are synchronised here; one clock, synchronous active-low reset.
module i2c_start_gen
    import i2c_start_pkg::*;
#(
    parameter int BAUD_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_set,
    input  logic [BAUD_W-1:0] reload,
    input  logic              release_bus,
    input  logic              clr_flags,
    input  logic              sda_in,
    input  logic              scl_in,
    output logic              sda_drive_low,
    output logic              scl_drive_low,
    output logic              start_en,
    output logic              start_done,
    output logic              start_seen,
    output logic              irq_flag,
    output logic              bus_coll
);
    localparam logic [BAUD_W-1:0] MIN_PERIOD = BAUD_W'(1);

    start_state_e      state;
    logic [1:0]        lines_s;
    logic              sda_s, scl_s;
    logic              cnt_load, cnt_dec, cnt_last, coll_evt;
    logic [BAUD_W-1:0] eff_reload;

    line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}), .synced(lines_s)
    );
    assign sda_s = lines_s[0];
    assign scl_s = lines_s[1];

    assign eff_reload = (reload == '0) ? MIN_PERIOD : reload;

    baud_down_counter #(.W(BAUD_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .dec(cnt_dec),
        .load_val(eff_reload), .last(cnt_last)
    );

    start_flags u_flags (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_s(scl_s),
        .coll_evt(coll_evt), .clr(clr_flags),
        .start_seen(start_seen), .irq_flag(irq_flag), .bus_coll(bus_coll)
    );

    // Decide collision, counter load and decrement from the state and line levels
    always_comb begin
        coll_evt = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        case (state)
            ST_CHECK: begin
                if (!sda_s || !scl_s) coll_evt = 1'b1;
                else                  cnt_load = 1'b1;
            end
            ST_COUNT1: begin
                if (!sda_s)         cnt_load = 1'b1;
                else if (!scl_s)    coll_evt = 1'b1;
                else if (cnt_last)  cnt_load = 1'b1;
                else                cnt_dec  = 1'b1;
            end
            ST_COUNT2: begin
                if (!cnt_last) cnt_dec = 1'b1;
            end
            default: ;
        endcase
    end

    // Advance the START sequence and drive the line enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            start_en      <= 1'b0;
            start_done    <= 1'b0;
            sda_drive_low <= 1'b0;
            scl_drive_low <= 1'b0;
        end else begin
            start_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_set) begin
                        start_en <= 1'b1;
                        state    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (coll_evt) begin
                        start_en <= 1'b0;
                        state    <= ST_IDLE;
                    end else begin
                        state <= ST_COUNT1;
                    end
                end
                ST_COUNT1: begin
                    if (coll_evt) begin
                        start_en <= 1'b0;
                        state    <= ST_IDLE;
                    end else if (cnt_load) begin
                        sda_drive_low <= 1'b1;
                        state         <= ST_COUNT2;
                    end
                end
                ST_COUNT2: begin
                    if (cnt_last) begin
                        scl_drive_low <= 1'b1;
                        start_done    <= 1'b1;
                        start_en      <= 1'b0;
                        state         <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (release_bus) begin
                        sda_drive_low <= 1'b0;
                        scl_drive_low <= 1'b0;
                        state         <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7
    scl_after_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_low |-> sda_drive_low);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |=> !start_done);

    // R3
    coll_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_coll) |-> (!start_en && !sda_drive_low && !scl_drive_low));

    // R10
    hold_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !release_bus) |=> (sda_drive_low && scl_drive_low));
endmodule

// File: tb/i2c_start_gen_test.sv
// Bench: sweeps reload values and disturbance points; expected edge indices are computed.
module i2c_start_gen_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_set = 1'b0;
    logic [6:0] reload = 7'd1;
    logic release_bus = 1'b0;
    logic clr_flags = 1'b0;
    logic other_sda = 1'b0;
    logic other_scl = 1'b0;
    logic sda_in, scl_in;
    logic sda_drive_low, scl_drive_low, start_en, start_done;
    logic start_seen, irq_flag, bus_coll;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    assign sda_in = ~(sda_drive_low | other_sda);
    assign scl_in = ~(scl_drive_low | other_scl);

    i2c_start_gen uut (
        .clk(clk), .rst_n(rst_n), .start_set(start_set), .reload(reload),
        .release_bus(release_bus), .clr_flags(clr_flags),
        .sda_in(sda_in), .scl_in(scl_in),
        .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
        .start_en(start_en), .start_done(start_done),
        .start_seen(start_seen), .irq_flag(irq_flag), .bus_coll(bus_coll)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Release the bus, settle the synchroniser, clear the flags
    task automatic cleanup();
        @(negedge clk);
        other_sda = 1'b0; other_scl = 1'b0; release_bus = 1'b1;
        @(negedge clk);
        release_bus = 1'b0;
        repeat (4) @(negedge clk);
        clr_flags = 1'b1;
        @(negedge clk);
        clr_flags = 1'b0;
        @(negedge clk);
    endtask

    // kind: 0 none, 1 other master pulls SDA at index j, 2 pulls SCL at index j
    task automatic run_start(input int r, input int kind, input int j);
        int le, n, t_sda, t_scl, t_done, t_coll, t_seen, t_irq, n_done;
        int e_sda, e_scl, e_coll, e_seen;
        le = (r == 0) ? 1 : r;
        n = 2 * le + 12;
        t_sda = -1; t_scl = -1; t_done = -1; t_coll = -1; t_seen = -1; t_irq = -1; n_done = 0;
        @(negedge clk);
        reload = 7'(r);
        start_set = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            start_set = 1'b0;
            if (k == 0) chk("R2 start_en on accept", int'(start_en), 1);
            if (sda_drive_low && t_sda < 0) t_sda = k;
            if (scl_drive_low && t_scl < 0) t_scl = k;
            if (start_done) begin n_done++; if (t_done < 0) t_done = k; end
            if (bus_coll && t_coll < 0) t_coll = k;
            if (start_seen && t_seen < 0) t_seen = k;
            if (irq_flag && t_irq < 0) t_irq = k;
            if (kind == 1 && k == j) other_sda = 1'b1;
            if (kind == 2 && k == j) other_scl = 1'b1;
        end
        e_sda = 1 + le; e_coll = -1;
        if (kind == 1 && j + 3 < 1 + le) e_sda = j + 3;
        e_scl = e_sda + le;
        e_seen = e_sda + 3;
        if (kind == 1 && j + 3 < e_seen) e_seen = j + 3;
        if (kind == 2 && j <= le - 2) begin
            e_coll = j + 3; e_sda = -1; e_scl = -1;
        end
        if (kind == 2) begin
            chk("R5 collision edge (SCL low in first period)", t_coll, e_coll);
            chk("R5 SDA drive edge", t_sda, e_sda);
            chk("R8 SCL drive edge, no collision in second period", t_scl, e_scl);
        end else begin
            chk(kind == 1 ? "R6 early SDA drive edge" : "R4 SDA drive edge", t_sda, e_sda);
            chk("R6 no collision", t_coll, -1);
            chk("R7 SCL drive edge", t_scl, e_scl);
            chk("R7 start_done edge", t_done, e_scl);
            chk("R7 start_done single pulse", n_done, 1);
            chk("R7 start_en cleared", int'(start_en), 0);
            chk("R9 start_seen edge", t_seen, e_seen);
            chk("R9 irq_flag edge", t_irq, e_seen);
            chk("R10 lines held", int'(sda_drive_low & scl_drive_low), 1);
        end
        cleanup();
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset sda drive", int'(sda_drive_low), 0);
        chk("R1 reset scl drive", int'(scl_drive_low), 0);
        chk("R1 reset flags", int'({start_en, start_done, start_seen, irq_flag, bus_coll}), 0);

        // Free bus, several periods including reload 0
        foreach (reload_set[i]) run_start(reload_set[i], 0, 0);
        run_start(127, 0, 0);

        // R5/R8 sweep SCL disturbance; R6 sweep SDA disturbance
        foreach (reload_set[i]) begin
            for (int j = 0; j <= reload_set[i] + 2; j++) run_start(reload_set[i], 2, j);
            for (int j = 0; j <= reload_set[i] + 2; j++) run_start(reload_set[i], 1, j);
        end

        // R3 line already low before the request
        for (int which = 0; which < 2; which++) begin
            @(negedge clk);
            if (which == 0) other_sda = 1'b1; else other_scl = 1'b1;
            repeat (4) @(negedge clk);
            start_set = 1'b1;
            @(negedge clk);
            start_set = 1'b0;
            chk("R3 start_en accepted", int'(start_en), 1);
            @(negedge clk);
            chk("R3 pre-start collision flag", int'(bus_coll), 1);
            chk("R3 start_en withdrawn", int'(start_en), 0);
            repeat (6) @(negedge clk);
            chk("R3 no line driven", int'(sda_drive_low | scl_drive_low), 0);
            chk("R11 collision sticky", int'(bus_coll), 1);
            cleanup();
            chk("R11 flags cleared", int'({bus_coll, irq_flag, start_seen}), 0);
        end

        // R2 request ignored while held; R10 release
        @(negedge clk);
        reload = 7'd2;
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 held after completion", int'(sda_drive_low & scl_drive_low), 1);
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        chk("R2 request ignored while held", int'(start_en), 0);
        repeat (3) @(negedge clk);
        chk("R2 no new done pulse", int'(start_done), 0);
        chk("R11 irq sticky", int'(irq_flag), 1);
        release_bus = 1'b1;
        @(negedge clk);
        release_bus = 1'b0;
        chk("R10 release frees both lines", int'(sda_drive_low | scl_drive_low), 0);
        cleanup();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    int reload_set[5] = '{0, 1, 2, 3, 5};
endmodule